// File: doc/BRIEF.md
# Peripheral-to-memory byte DMA channel with source address reload

This block is a single DMA channel that moves bytes from a peripheral data register into memory. A configuration strobe loads four things: the start source address, the start destination address, a transfer count and a reload option. Each peripheral request pulse makes the channel ask for the bus. Once the bus is granted, the channel runs a burst of back-to-back transfers over a simple valid/ready master port. Each transfer is one byte read followed by one byte write.

With reload off, a single request runs the whole count as one burst, and both addresses step forward by one per byte. With reload on, the work is split into groups of four transfers. After the fourth transfer of a group, the source address returns to its programmed start and the channel gives up the bus. It then waits for the next peripheral request before it starts the next group. The destination address keeps advancing in both modes. When the count reaches zero, the channel disarms itself and raises an interrupt, which stays high until it is acknowledged.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset, `bus_req_o`, `m_valid_o` and `irq_o` are low, and no request has any effect until the channel is configured.
- R2: Each transfer is a read (`m_write_o`=0) from the source address, then a write (`m_write_o`=1) to the destination address carrying the byte returned by that read. A cycle completes only in a cycle where `m_ready_i` is high. Address and direction hold while `m_ready_i` is low.
- R3: The destination address of transfer i is the programmed start plus i, in both modes.
- R4: With reload off (`cfg_reload_i`=0), the source address of transfer i is the programmed start plus i.
- R5: With reload on, the source address of transfer i is the programmed start plus (i mod 4). It returns to the start after every fourth transfer.
- R6: `m_valid_o` is asserted only while `bus_req_o` is high. The first cycle after an idle period starts only after `bus_gnt_i` was seen high. Within a burst, `bus_req_o` stays high between transfers. With reload off, the burst covers the whole count.
- R7: With reload on, `bus_req_o` falls after the fourth transfer of a group. The next group starts only after a peripheral request (`dreq_i` high for a cycle).
- R8: A request that arrives while a group is in progress is remembered. It starts the next group without a further request.
- R9: The count drops by one per completed transfer. A final group may be shorter than four. After the last transfer the channel disarms, and further requests cause no bus activity.
- R10: `irq_o` rises after the last transfer completes. It stays high until `irq_ack_i` is pulsed.
- R11: A `cfg_load_i` pulse loads the addresses, count and reload option, clears `irq_o` and any remembered request, and arms the channel when the count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load configuration and arm |
| cfg_src_i | input | ADDR_W | Start source address |
| cfg_dst_i | input | ADDR_W | Start destination address |
| cfg_count_i | input | CNT_W | Number of byte transfers |
| cfg_reload_i | input | 1 | 1 = source reload after each group of four |
| dreq_i | input | 1 | Peripheral transfer request |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus grant |
| m_valid_o | output | 1 | Master cycle valid |
| m_write_o | output | 1 | 1 = write cycle, 0 = read cycle |
| m_addr_o | output | ADDR_W | Master address |
| m_wdata_o | output | DATA_W | Write data |
| m_rdata_i | input | DATA_W | Read data |
| m_ready_i | input | 1 | Slave ready; completes the current cycle |
| irq_o | output | 1 | End-of-transfer interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge |

## Verification
The main function is run four ways:
- A full 128-byte reload run with requests spaced apart. Its source address pattern separates reload from plain stepping, and its bus drops separate group release from a single burst.
- A 10-byte run with reload off, started by a single request, with addresses that cross a byte carry. It shows one continuous burst with both addresses advancing.
- A run where a second request lands inside the first group. It shows that the request is held and that the channel stalls after exactly two groups.
- A 5-byte reload run that ends with a single-transfer group. It exercises the count reaching zero at a group other than a full one.

Read data varies with the address, and the slave inserts wait states, so a wrongly captured byte or a cycle that completes early would show up in the data checks.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR
  } dma_st_e;
endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // set wins over clr so a request in the grant cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (flush_i) pend_q <= 1'b0;
    else              pend_q <= set_i | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int unsigned ADDR_W     = 32,
  parameter bit          HAS_RELOAD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] init_i,
  input  logic              step_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, next_addr;

  generate
    if (HAS_RELOAD) begin : g_reload
      logic [ADDR_W-1:0] base_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     base_q <= '0;
        else if (load_i) base_q <= init_i;
      end
      assign next_addr = reload_i ? base_q : addr_q + 1'b1;
    end else begin : g_plain
      logic unused_reload;
      assign unused_reload = reload_i;
      assign next_addr     = addr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= init_i;
    else if (step_i) addr_q <= next_addr;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GROUP_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  output logic             last_o,
  output logic             group_end_o
);
  localparam int unsigned GRP_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;

  logic [CNT_W-1:0] tcr_q;
  logic [GRP_W-1:0] grp_q;

  assign last_o      = (tcr_q == CNT_W'(1));
  assign group_end_o = (grp_q == GRP_W'(GROUP_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcr_q <= '0;
      grp_q <= '0;
    end else if (load_i) begin
      tcr_q <= count_i;
      grp_q <= '0;
    end else if (step_i) begin
      tcr_q <= tcr_q - 1'b1;
      grp_q <= group_end_o ? '0 : grp_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_reload_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GROUP_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic              cfg_reload_i,
  input  logic              dreq_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              m_valid_o,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic [DATA_W-1:0] m_rdata_i,
  input  logic              m_ready_i,
  output logic              irq_o,
  input  logic              irq_ack_i
);
  dma_st_e st_q, st_d;
  logic en_q, reload_q, irq_q;
  logic [DATA_W-1:0] buf_q;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic pend, last, group_end;
  logic rd_done, wr_done, grp_start, src_reload;

  assign rd_done    = (st_q == ST_RD) && m_ready_i;
  assign wr_done    = (st_q == ST_WR) && m_ready_i;
  assign grp_start  = (st_q == ST_REQ) && bus_gnt_i;
  assign src_reload = reload_q && group_end;

  dma_req_latch u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(cfg_load_i),
    .set_i  (dreq_i && en_q),
    .clr_i  (grp_start),
    .pend_o (pend)
  );

  dma_addr_step #(.ADDR_W(ADDR_W), .HAS_RELOAD(1'b1)) u_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load_i),
    .init_i  (cfg_src_i),
    .step_i  (wr_done),
    .reload_i(src_reload),
    .addr_o  (src_addr)
  );

  dma_addr_step #(.ADDR_W(ADDR_W), .HAS_RELOAD(1'b0)) u_dst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load_i),
    .init_i  (cfg_dst_i),
    .step_i  (wr_done),
    .reload_i(1'b0),
    .addr_o  (dst_addr)
  );

  dma_xfer_count #(.CNT_W(CNT_W), .GROUP_LEN(GROUP_LEN)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load_i),
    .count_i    (cfg_count_i),
    .step_i     (wr_done),
    .last_o     (last),
    .group_end_o(group_end)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (en_q && pend) st_d = ST_REQ;
      ST_REQ:  if (bus_gnt_i)    st_d = ST_RD;
      ST_RD:   if (m_ready_i)    st_d = ST_WR;
      ST_WR: begin
        if (m_ready_i) st_d = (last || src_reload) ? ST_IDLE : ST_RD;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cfg_load_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      en_q     <= 1'b0;
      reload_q <= 1'b0;
      irq_q    <= 1'b0;
      buf_q    <= '0;
    end else begin
      st_q <= st_d;
      if (rd_done) buf_q <= m_rdata_i;
      if (cfg_load_i) begin
        en_q     <= (cfg_count_i != '0);
        reload_q <= cfg_reload_i;
        irq_q    <= 1'b0;
      end else if (wr_done && last) begin
        en_q  <= 1'b0;
        irq_q <= 1'b1;
      end else if (irq_ack_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign bus_req_o = (st_q != ST_IDLE);
  assign m_valid_o = (st_q == ST_RD) || (st_q == ST_WR);
  assign m_write_o = (st_q == ST_WR);
  assign m_addr_o  = (st_q == ST_WR) ? dst_addr : src_addr;
  assign m_wdata_o = buf_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/dma_reload_chan_chk.sv
module dma_reload_chan_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_load_i,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              m_valid_o,
  input logic              m_write_o,
  input logic [ADDR_W-1:0] m_addr_o,
  input logic              m_ready_i,
  input logic              irq_o,
  input logic              irq_ack_i
);
  AST_CYCLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i && !cfg_load_i) |=>
      (m_valid_o && $stable(m_addr_o) && $stable(m_write_o))); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_write_o && m_ready_i && !cfg_load_i) |=> (m_valid_o && m_write_o)); // R2

  AST_WRITE_NOT_REPEATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_write_o && m_ready_i) |=> !(m_valid_o && m_write_o)); // R2

  AST_OWNS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> bus_req_o); // R6

  AST_START_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_valid_o) |-> $past(bus_gnt_i)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i && !cfg_load_i) |=> irq_o); // R10
endmodule

bind dma_reload_chan dma_reload_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_load_i(cfg_load_i),
  .bus_req_o (bus_req_o),
  .bus_gnt_i (bus_gnt_i),
  .m_valid_o (m_valid_o),
  .m_write_o (m_write_o),
  .m_addr_o  (m_addr_o),
  .m_ready_i (m_ready_i),
  .irq_o     (irq_o),
  .irq_ack_i (irq_ack_i)
);

// File: tb/dma_reload_chan_tb_top.sv
`timescale 1ns/1ps
module dma_reload_chan_tb_top;
  localparam int AW = 32;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_load_i = 1'b0, cfg_reload_i = 1'b0;
  logic [AW-1:0] cfg_src_i = '0, cfg_dst_i = '0;
  logic [CW-1:0] cfg_count_i = '0;
  logic dreq_i = 1'b0, bus_gnt_i = 1'b0, m_ready_i = 1'b0, irq_ack_i = 1'b0;
  logic [DW-1:0] m_rdata_i = '0;
  logic bus_req_o, m_valid_o, m_write_o, irq_o;
  logic [AW-1:0] m_addr_o;
  logic [DW-1:0] m_wdata_o;

  always #2 clk = ~clk;

  dma_reload_chan dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .cfg_src_i(cfg_src_i),
    .cfg_dst_i(cfg_dst_i), .cfg_count_i(cfg_count_i), .cfg_reload_i(cfg_reload_i),
    .dreq_i(dreq_i), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .m_valid_o(m_valid_o), .m_write_o(m_write_o), .m_addr_o(m_addr_o),
    .m_wdata_o(m_wdata_o), .m_rdata_i(m_rdata_i), .m_ready_i(m_ready_i),
    .irq_o(irq_o), .irq_ack_i(irq_ack_i)
  );

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [7:0]  data;
    bit          gap;
    string       atag;
    string       gtag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit dropped = 1'b1;

  function automatic logic [7:0] rd_fn(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: expected master cycles of one configured run
  task automatic push_run(logic [31:0] src, logic [31:0] dst, int count, bit reload);
    for (int i = 0; i < count; i++) begin
      item_t r, w;
      r.wr   = 1'b0;
      r.addr = reload ? src + 32'(i % 4) : src + 32'(i);
      r.data = 8'h00;
      r.gap  = reload ? (i % 4 == 0) : (i == 0);
      r.atag = reload ? "R5" : "R4";
      r.gtag = reload ? "R7" : "R6";
      w.wr   = 1'b1;
      w.addr = dst + 32'(i);
      w.data = rd_fn(r.addr);
      w.gap  = 1'b0;
      w.atag = "R3";
      w.gtag = "R6";
      exp_q.push_back(r);
      exp_q.push_back(w);
    end
  endtask

  // slave, grant and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_ready_i = 1'b0;
      bus_gnt_i = 1'b0;
    end else begin
      bus_gnt_i = bus_req_o;
      m_ready_i = (cyc % 3 != 1);
      m_rdata_i = rd_fn(m_addr_o);
      if (!bus_req_o) dropped = 1'b1;
      if (m_valid_o && m_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected master cycle addr", m_addr_o, 32'h0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(m_write_o == e.wr, "R2", "cycle direction", 32'(m_write_o), 32'(e.wr));
          chk(m_addr_o == e.addr, e.atag, "cycle address", m_addr_o, e.addr);
          if (e.wr) chk(m_wdata_o == e.data, "R2", "write data", 32'(m_wdata_o), 32'(e.data));
          else      chk(dropped == e.gap, e.gtag, "bus release before read", 32'(dropped), 32'(e.gap));
        end
        dropped = 1'b0;
      end
    end
  end

  task automatic load(logic [31:0] s, logic [31:0] d, int n, bit rl);
    @(negedge clk);
    cfg_src_i = s; cfg_dst_i = d; cfg_count_i = CW'(n); cfg_reload_i = rl; cfg_load_i = 1'b1;
    @(negedge clk);
    cfg_load_i = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); dreq_i = 1'b1;
    @(negedge clk); dreq_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired with %0d cycles pending", exp_q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req_o == 1'b0 && m_valid_o == 1'b0 && irq_o == 1'b0, "R1", "outputs in reset",
        {bus_req_o, m_valid_o, irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(bus_req_o == 1'b0 && m_valid_o == 1'b0 && irq_o == 1'b0, "R1", "outputs after reset",
        {bus_req_o, m_valid_o, irq_o}, 32'h0);
    pulse_req();
    repeat (20) @(negedge clk);
    chk(bus_req_o == 1'b0, "R1", "request before configure", 32'(bus_req_o), 32'h0);

    // full reload run: 128 bytes in 32 groups
    load(32'h0000_0100, 32'h0000_2000, 128, 1'b1);
    push_run(32'h0000_0100, 32'h0000_2000, 128, 1'b1);
    for (int g = 0; g < 32; g++) begin
      pulse_req();
      repeat (30) @(negedge clk);
      if (g == 30) chk(irq_o == 1'b0, "R10", "irq before last group", 32'(irq_o), 32'h0);
    end
    wait_empty();
    chk(irq_o == 1'b1, "R10", "irq after full count", 32'(irq_o), 32'h1);
    repeat (10) @(negedge clk);
    chk(irq_o == 1'b1, "R10", "irq held until ack", 32'(irq_o), 32'h1);
    pulse_req();
    repeat (30) @(negedge clk);
    chk(bus_req_o == 1'b0, "R9", "request after completion", 32'(bus_req_o), 32'h0);
    ack();
    chk(irq_o == 1'b0, "R10", "irq after ack", 32'(irq_o), 32'h0);

    // reload off: single burst crossing a carry
    load(32'h0000_03FE, 32'h0000_80F8, 10, 1'b0);
    push_run(32'h0000_03FE, 32'h0000_80F8, 10, 1'b0);
    pulse_req();
    wait_empty();
    chk(irq_o == 1'b1, "R6", "burst completes on one request", 32'(irq_o), 32'h1);
    ack();

    // request during a group is held
    load(32'h0000_0040, 32'h0000_0500, 16, 1'b1);
    push_run(32'h0000_0040, 32'h0000_0500, 16, 1'b1);
    pulse_req();
    repeat (6) @(negedge clk);
    pulse_req();
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 16, "R8", "remaining cycles after two groups", exp_q.size(), 32'd16);
    chk(bus_req_o == 1'b0, "R7", "bus released waiting for request", 32'(bus_req_o), 32'h0);
    chk(irq_o == 1'b0, "R10", "irq while count remains", 32'(irq_o), 32'h0);
    pulse_req();
    repeat (30) @(negedge clk);
    pulse_req();
    wait_empty();
    chk(irq_o == 1'b1, "R10", "irq after held-request run", 32'(irq_o), 32'h1);

    // load clears irq; partial last group
    load(32'h0000_0010, 32'h0000_0600, 5, 1'b1);
    chk(irq_o == 1'b0, "R11", "irq cleared by load", 32'(irq_o), 32'h0);
    push_run(32'h0000_0010, 32'h0000_0600, 5, 1'b1);
    pulse_req();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 2, "R9", "one transfer left in short group", exp_q.size(), 32'd2);
    pulse_req();
    wait_empty();
    chk(irq_o == 1'b1, "R9", "irq after short last group", 32'(irq_o), 32'h1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && bus_req_o == 1'b0, "R9", "idle after short run", 32'(bus_req_o), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule